// File: doc/BRIEF.md
# Byte-Wide EEPROM Command Controller

This block lets a host run single-byte read and write operations against an external byte-wide non-volatile memory. The host sees two 32-bit registers. The command word at offset 0x00 holds four things: the byte address, a two-bit operation code, a start/busy bit and a sticky timeout flag. The data word at offset 0x04 holds the byte to be written or the byte that was read. The memory side is a plain request/acknowledge port. The request stays high for the whole operation. The memory answers with a single-cycle acknowledge and, for a read, the byte.

To write a byte, the host loads the data word and then writes the command word with the write code and the start bit set. To read a byte, it writes the command word with any other code and the start bit set. It then polls until busy drops and reads the data word. If no acknowledge arrives within `TIMEOUT` cycles, the operation is abandoned and the timeout flag is set. For this reason, setting the start bit with no memory attached works as a presence probe.

Top module: `eectl_top`

## Requirements
- R1: After reset the command word reads 0, the data word reads 0 and `mem_req` is low.
- R2: A host write of the command word (offset 0x00) with bit 31 set, while idle, starts an operation. From the next cycle until the operation ends, bit 31 reads 1, `mem_req` is high and `mem_addr`, `mem_we` and `mem_wdata` hold steady, with `mem_addr` equal to the address field.
- R3: Operation code bits 29:28 equal to 2'b11 make a write, with `mem_we` high and `mem_wdata` equal to the data word's low byte. Every other code (00, 01, 10) makes a read, with `mem_we` low.
- R4: When the memory acknowledges, busy clears at that clock edge. For a read, the data word's low byte takes `mem_rdata` at the same edge. An acknowledge given L cycles after the request makes busy last L+1 cycles.
- R5: If no acknowledge has arrived after `TIMEOUT` busy cycles, busy clears and bit 17 (timeout flag) sets. An acknowledge in the last allowed cycle completes normally with no timeout.
- R6: The timeout flag stays set until a write to the command word has bit 17 at 1, made while idle. Writing bit 17 as 0 leaves the flag unchanged.
- R7: Host writes to either register while busy are ignored. The address, code, data and memory write that are in progress stay unchanged.
- R8: Setting the start bit with no memory responding ends in the timeout flag set after exactly `TIMEOUT` busy cycles.
- R9: The command word reads back busy at bit 31, the code at 29:28, the timeout flag at 17 and the address at bits ADDR_W-1:0, with all other bits 0. The data word reads back its byte in bits DATA_W-1:0 with zeros above. Other register offsets read 0 and ignore writes. A command write with bit 31 clear updates the address and code without starting anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | REG_AW | Register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register read data for `host_addr` (combinational) |
| mem_req | output | 1 | Memory operation request, high while busy |
| mem_we | output | 1 | 1 = write byte, 0 = read byte |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | DATA_W | Byte to write |
| mem_ack | input | 1 | Single-cycle completion from the memory |
| mem_rdata | input | DATA_W | Read byte, valid with `mem_ack` |

## Verification
The bench builds the block with ADDR_W = 4 and TIMEOUT = 5. This gives a 16-byte space, so every address can be written and read back with computed byte patterns while all three read codes rotate. The short timeout lets the bench sweep acknowledge latency from 0 up to TIMEOUT+1. That sweep covers the last-cycle acknowledge that must still win and the first latency that must time out, and each case is followed by a flag clear. The same small configuration keeps the no-memory probe and the writes made while busy down to a few cycles each.

// File: rtl/eectl_pkg.sv
package eectl_pkg;
  // Command word layout; the host software decodes these positions.
  localparam int BUSY_POS = 31;
  localparam int OPHI_POS = 29;
  localparam int OPLO_POS = 28;
  localparam int TMO_POS  = 17;

  localparam logic [1:0] OP_WRITE = 2'b11;

  function automatic logic is_write(input logic [1:0] op);
    return op == OP_WRITE;
  endfunction

  // Assemble the command word seen by the host (address already zero-extended).
  function automatic logic [31:0] cmd_view(input logic busy, input logic [1:0] op,
                                           input logic tmo, input logic [31:0] addr_z);
    logic [31:0] v;
    v = addr_z;
    v[BUSY_POS] = busy;
    v[OPHI_POS:OPLO_POS] = op;
    v[TMO_POS] = tmo;
    return v;
  endfunction
endpackage

// File: rtl/eectl_hostif.sv
module eectl_hostif #(
  parameter int REG_AW = 3,
  parameter int DATA_W = 8
) (
  input  logic              host_wr,
  input  logic [REG_AW-1:0] host_addr,
  input  logic              busy,
  input  logic [31:0]       cmd_word,
  input  logic [DATA_W-1:0] data_byte,
  output logic              cmd_hit,
  output logic              cmd_wr,
  output logic              data_wr,
  output logic [31:0]       host_rdata
);
  localparam logic [REG_AW-1:0] CMD_OFS  = REG_AW'(0);
  localparam logic [REG_AW-1:0] DATA_OFS = REG_AW'(4);

  logic data_hit;

  always_comb begin
    cmd_hit  = host_wr && (host_addr == CMD_OFS);
    data_hit = host_wr && (host_addr == DATA_OFS);
    cmd_wr   = cmd_hit && !busy;
    data_wr  = data_hit && !busy;
    if (host_addr == CMD_OFS)
      host_rdata = cmd_word;
    else if (host_addr == DATA_OFS)
      host_rdata = {{(32-DATA_W){1'b0}}, data_byte};
    else
      host_rdata = '0;
  end
endmodule

// File: rtl/eectl_seq.sv
module eectl_seq #(
  parameter int ADDR_W  = 13,
  parameter int TIMEOUT = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              start,
  input  logic              tmo_clr,
  input  logic [1:0]        op_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              mem_ack,
  output logic              busy,
  output logic              tmo_flag,
  output logic [1:0]        op,
  output logic [ADDR_W-1:0] addr,
  output logic              done_evt,
  output logic              tmo_evt,
  output logic              rd_done
);
  import eectl_pkg::*;

  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] wait_cnt;

  always_comb begin
    done_evt = busy && mem_ack;
    tmo_evt  = busy && !mem_ack && (wait_cnt == LAST);
    rd_done  = done_evt && !is_write(op);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      tmo_flag <= 1'b0;
      op       <= '0;
      addr     <= '0;
      wait_cnt <= '0;
    end else if (cmd_wr) begin
      op   <= op_in;
      addr <= addr_in;
      if (tmo_clr) tmo_flag <= 1'b0;
      if (start) begin
        busy     <= 1'b1;
        wait_cnt <= '0;
      end
    end else if (done_evt) begin
      busy <= 1'b0;
    end else if (tmo_evt) begin
      busy     <= 1'b0;
      tmo_flag <= 1'b1;
    end else if (busy) begin
      wait_cnt <= wait_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/eectl_datareg.sv
module eectl_datareg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_done,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] data_byte
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      data_byte <= '0;
    else if (data_wr)
      data_byte <= wdata;
    else if (rd_done)
      data_byte <= mem_rdata;
  end
endmodule

// File: rtl/eectl_top.sv
module eectl_top #(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int REG_AW  = 3,
  parameter int TIMEOUT = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [REG_AW-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  import eectl_pkg::*;

  logic              busy_q, tmo_q, cmd_hit, cmd_wr, data_wr;
  logic              done_evt, tmo_evt, rd_done;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_byte;
  logic [31:0]       cmd_word;

  assign cmd_word = cmd_view(busy_q, op_q, tmo_q, {{(32-ADDR_W){1'b0}}, addr_q});

  eectl_hostif #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_hostif (
    .host_wr(host_wr), .host_addr(host_addr), .busy(busy_q),
    .cmd_word(cmd_word), .data_byte(data_byte),
    .cmd_hit(cmd_hit), .cmd_wr(cmd_wr), .data_wr(data_wr),
    .host_rdata(host_rdata)
  );

  eectl_seq #(.ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr),
    .start(host_wdata[BUSY_POS]), .tmo_clr(host_wdata[TMO_POS]),
    .op_in(host_wdata[OPHI_POS:OPLO_POS]), .addr_in(host_wdata[ADDR_W-1:0]),
    .mem_ack(mem_ack), .busy(busy_q), .tmo_flag(tmo_q), .op(op_q), .addr(addr_q),
    .done_evt(done_evt), .tmo_evt(tmo_evt), .rd_done(rd_done)
  );

  eectl_datareg #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .wdata(host_wdata[DATA_W-1:0]),
    .rd_done(rd_done), .mem_rdata(mem_rdata), .data_byte(data_byte)
  );

  assign mem_req   = busy_q;
  assign mem_we    = is_write(op_q);
  assign mem_addr  = addr_q;
  assign mem_wdata = data_byte;
endmodule

// File: rtl/eectl_checker.sv
module eectl_checker #(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int TIMEOUT = 20000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              cmd_hit,
  input logic              tmo_flag,
  input logic              tmo_evt,
  input logic [DATA_W-1:0] data_byte
);
  localparam int RUN_W = $clog2(TIMEOUT + 2);
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n || !mem_req) run <= '0;
    else run <= run + 1'b1;
  end

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> (!mem_req || ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)))); // R2
  AST_ACK_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req); // R4
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_we |=> data_byte == $past(mem_rdata)); // R4
  AST_TMO_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> tmo_flag && !mem_req); // R5
  AST_TMO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> $past(mem_req) && !$past(mem_ack)); // R5
  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> run < RUN_W'(TIMEOUT)); // R5
  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && cmd_hit |=> $stable(mem_addr)); // R7
endmodule

bind eectl_top eectl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .cmd_hit(cmd_hit),
  .tmo_flag(tmo_q), .tmo_evt(tmo_evt), .data_byte(data_byte)
);

// File: tb/tb_eectl_top.sv
module tb_eectl_top;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int REG_AW  = 3;
  localparam int TIMEOUT = 5;
  localparam int NBYTES  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [REG_AW-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  int lat = 0;
  bit present = 1'b1;
  int wait_cnt = 0;
  logic [7:0] tb_mem [NBYTES];

  always #2 clk = ~clk;

  eectl_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW), .TIMEOUT(TIMEOUT)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  // Memory model: acknowledges lat negedges after the request is first seen.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
        wait_cnt = 0;
      end else if (mem_req && present) begin
        if (wait_cnt == lat) begin
          mem_ack = 1'b1;
          mem_rdata = tb_mem[mem_addr];
          if (mem_we) tb_mem[mem_addr] = mem_wdata;
          wait_cnt = 0;
        end else wait_cnt++;
      end else wait_cnt = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [REG_AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_wr = 1'b0; host_addr = '0;
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, output logic [31:0] v);
    host_addr = a;
    #1 v = host_rdata;
    host_addr = '0;
  endtask

  // Called at the negedge after the start write; returns busy cycle count.
  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    rd(0, v);
    while (v[31] && cyc < 50) begin
      cyc++;
      @(negedge clk);
      rd(0, v);
    end
  endtask

  function automatic logic [31:0] cmd(input logic go, input logic [1:0] op,
                                      input logic clr, input int a);
    logic [31:0] c;
    c = 32'(a) & 32'(NBYTES - 1);
    c[31] = go; c[29:28] = op; c[17] = clr;
    return c;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cyc;
    for (int i = 0; i < NBYTES; i++) tb_mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, v); chk("R1 cmd", v, 0);
    rd(4, v); chk("R1 data", v, 0);
    chk("R1 mem_req", {31'b0, mem_req}, 0);

    // R3/R4 write every address with op 11
    for (int a = 0; a < NBYTES; a++) begin
      lat = a % 4;
      wr(4, {24'hABCDEF, pat(a)});
      wr(0, cmd(1, 2'b11, 0, a));
      chk("R2 mem_req high", {31'b0, mem_req}, 1);
      chk("R2 mem_addr", 32'(mem_addr), 32'(a));
      wait_idle(cyc);
      chk("R4 write busy cycles", 32'(cyc), 32'(lat + 1));
      chk("R3 byte written", {24'b0, tb_mem[a]}, {24'b0, pat(a)});
    end
    // R3/R4 read every address with rotating read codes
    for (int a = 0; a < NBYTES; a++) begin
      logic [1:0] op;
      op = 2'(a % 3);
      lat = (a + 1) % 4;
      wr(0, cmd(1, op, 0, a));
      chk("R3 read mem_we low", {31'b0, mem_we}, 0);
      wait_idle(cyc);
      chk("R4 read busy cycles", 32'(cyc), 32'(lat + 1));
      rd(4, v); chk("R4 read data", v, {24'b0, pat(a)});
      rd(0, v); chk("R9 cmd readback", v, cmd(0, op, 0, a));
      chk("R3 no write on read", {24'b0, tb_mem[a]}, {24'b0, pat(a)});
    end
    // R5/R6 latency sweep across the timeout boundary
    for (int l = 0; l <= TIMEOUT + 1; l++) begin
      int exp_cyc;
      lat = l;
      wr(0, cmd(1, 2'b00, 0, 5));
      wait_idle(cyc);
      exp_cyc = (l + 1 < TIMEOUT) ? l + 1 : TIMEOUT;
      chk("R5 busy cycles", 32'(cyc), 32'(exp_cyc));
      rd(0, v); chk("R5 timeout flag", {31'b0, v[17]}, {31'b0, (l >= TIMEOUT)});
      if (l < TIMEOUT) begin
        rd(4, v); chk("R5 data after ack", v, {24'b0, pat(5)});
      end else begin
        repeat (3) @(negedge clk);
        wr(0, cmd(0, 2'b00, 0, 5));
        rd(0, v); chk("R6 flag kept on 0 write", {31'b0, v[17]}, 1);
        wr(0, cmd(0, 2'b00, 1, 5));
        rd(0, v); chk("R6 flag cleared", {31'b0, v[17]}, 0);
      end
    end
    // R8 probe with no memory
    present = 1'b0;
    wr(0, 32'h8000_0000);
    wait_idle(cyc);
    chk("R8 probe busy cycles", 32'(cyc), TIMEOUT);
    rd(0, v); chk("R8 probe flag", v, 32'h0002_0000);
    wr(0, cmd(0, 2'b00, 1, 0));
    present = 1'b1;
    // R7 writes while busy are ignored
    lat = 3;
    wr(0, cmd(1, 2'b00, 0, 2));
    wr(0, cmd(1, 2'b11, 0, 9));
    wr(4, 32'h0000_0077);
    wait_idle(cyc);
    rd(4, v); chk("R7 data kept", v, {24'b0, pat(2)});
    rd(0, v); chk("R7 cmd kept", v, cmd(0, 2'b00, 0, 2));
    chk("R7 no write at 9", {24'b0, tb_mem[9]}, {24'b0, pat(9)});
    // R9 field packing and unused offsets
    wr(0, 32'h0BCD_FF0A);
    chk("R9 no start", {31'b0, mem_req}, 0);
    rd(0, v); chk("R9 cmd bits", v, 32'h0000_000A);
    wr(4, 32'hFFFF_FF5A);
    rd(4, v); chk("R9 data bits", v, 32'h0000_005A);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v); chk("R9 other offset", v, 0);
    rd(0, v); chk("R9 cmd unchanged", v, 32'h0000_000A);
    chk("R9 no start from other", {31'b0, mem_req}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule